// File: doc/BRIEF.md
# Dual-Channel IDE Bus-Master DMA Register Block

This block is the host-visible byte register file for a two-channel IDE bus-master DMA controller. A host writes and reads single bytes over a small synchronous register bus. Each channel has a command byte, a status byte, a drive timing byte and a 32-bit descriptor table pointer. One mode byte is shared by both channels. It carries latched copies of the two channel interrupt levels and a software block bit per channel.

The block merges the two channel interrupts into one level-sensitive interrupt output. A channel contributes to that output only while its latched flag is set and its block bit is clear. The transfer engine drives the read-only "DMA active" status bit. It also pulses set requests for the error and interrupt status bits. Software clears those two bits by writing ones to them. The command byte and the aligned descriptor pointer of each channel are driven out to the engine.

Top module: `ide_dma_regfile`

## Requirements
- R1: Address bit 3 selects the channel (0 or 1). Address bit 2 set selects the descriptor pointer byte given by bits 1:0, little-endian. With bit 2 clear, bits 1:0 select command (0), shared mode (1), status (2) or timing (3).
- R2: The command byte of each channel is a plain read/write byte. It is driven on `chan_cmd` (channel 0 in bits 7:0) from the cycle after the write.
- R3: A write to the shared mode byte, through either channel's window, updates only bits 4 and 5 (block bits of channel 0 and 1). Every other bit keeps its value.
- R4: Mode bits 2 and 3 follow the level of `chan_irq_in[0]` and `chan_irq_in[1]`, one clock later. Mode bits 0, 1, 6 and 7 read zero.
- R5: `irq_out` is high exactly when (mode bit 2 and not bit 4) or (mode bit 3 and not bit 5). It takes its new value one clock after an input change or a mode write.
- R6: In a status write, bits 5 and 6 take the written value. Bits 3, 4 and 7 read zero. Bit 0 always shows `eng_active` of that channel, delayed one clock, and software writes cannot change it.
- R7: Status bits 1 (error) and 2 (interrupt) are write-one-to-clear. A written 1 clears the bit and a written 0 leaves it unchanged.
- R8: A pulse on `eng_err_set` sets status bit 1 and a pulse on `eng_int_set` sets status bit 2. When a set and a software clear hit the same bit in the same cycle, the set wins.
- R9: The two timing bytes are independent plain read/write bytes.
- R10: Each descriptor pointer byte is written separately. Bits 1:0 of the pointer always read zero, on the bus and on `desc_addr`.
- R11: A synchronous reset clears command, status, mode, timing and pointer registers in both channels and forces `irq_out` low.
- R12: `bus_rdata` is zero whenever `bus_rd` is low. Reads are combinational and have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| chan_irq_in | input | 2 | Interrupt level of each IDE channel |
| eng_active | input | 2 | DMA active level per channel from the engine |
| eng_err_set | input | 2 | Error status set pulse per channel |
| eng_int_set | input | 2 | Interrupt status set pulse per channel |
| irq_out | output | 1 | Combined level interrupt |
| chan_cmd | output | 16 | Command byte per channel |
| desc_addr | output | 64 | Descriptor table pointer per channel |

## Verification
The hardest condition to reach is a software write-one-to-clear that lands on the same edge as an engine set pulse for the same status bit. The bench drives both on one cycle and checks that the bit survives. It then reads the byte back after a plain clear to show the race, not the write, decided the result. The write-one-to-clear sweep runs every write value against a status byte that the engine pulses have just filled. The interrupt combiner is swept over all sixteen combinations of input levels and block bits.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;

    localparam int NCH      = 2;
    localparam int DW       = 8;
    localparam int PTR_W    = 32;
    localparam int LANES    = PTR_W / DW;
    localparam int CH_SEL_W = $clog2(NCH);
    localparam int ADDR_W   = CH_SEL_W + 3;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_TIME = 2'd3
    } reg_sel_e;

    localparam int ST_ACT = 0;
    localparam int ST_ERR = 1;
    localparam int ST_INT = 2;
    localparam logic [DW-1:0] ST_PLAIN_MASK = 8'h60;
    localparam logic [DW-1:0] ST_W1C_MASK   = 8'h06;

    localparam int MD_FLAG_LSB  = 2;
    localparam int MD_BLOCK_LSB = 4;
    localparam logic [DW-1:0] MD_SW_MASK = 8'h30;

    typedef struct packed {
        logic             cmd;
        logic             stat;
        logic             timing;
        logic [LANES-1:0] lane;
    } chan_we_t;

    typedef struct packed {
        logic [DW-1:0]    cmd;
        logic [DW-1:0]    stat;
        logic [DW-1:0]    timing;
        logic [PTR_W-1:0] ptr;
    } chan_view_t;

    function automatic logic [DW-1:0] stat_sw_update(
        input logic [DW-1:0] cur,
        input logic [DW-1:0] wval
    );
        return (wval & ST_PLAIN_MASK) | (cur & ST_W1C_MASK & ~wval);
    endfunction

endpackage

// File: rtl/ide_addr_dec.sv
module ide_addr_dec
    import ide_dma_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output chan_we_t          we [NCH],
    output logic              mode_we
);
    logic [CH_SEL_W-1:0] ch;
    reg_sel_e            sel;
    logic                in_ptr;

    assign ch     = addr[ADDR_W-1:3];
    assign in_ptr = addr[2];
    assign sel    = reg_sel_e'(addr[1:0]);

    assign mode_we = wr && !in_ptr && (sel == SEL_MODE);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = wr && (ch == CH_SEL_W'(c));
        assign we[c].cmd    = hit && !in_ptr && (sel == SEL_CMD);
        assign we[c].stat   = hit && !in_ptr && (sel == SEL_STAT);
        assign we[c].timing = hit && !in_ptr && (sel == SEL_TIME);
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign we[c].lane[l] = hit && in_ptr && (addr[1:0] == 2'(l));
        end
    end
endmodule

// File: rtl/ide_chan_regs.sv
module ide_chan_regs
    import ide_dma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  chan_we_t      we,
    input  logic [DW-1:0] wdata,
    input  logic          active,
    input  logic          err_set,
    input  logic          int_set,
    output chan_view_t    view
);
    logic [DW-1:0]    cmd_q, stat_q, time_q, stat_d;
    logic [PTR_W-1:0] ptr_q;

    always_comb begin
        stat_d = we.stat ? stat_sw_update(stat_q, wdata) : stat_q;
        stat_d[ST_ACT] = active;
        if (err_set) stat_d[ST_ERR] = 1'b1;
        if (int_set) stat_d[ST_INT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            stat_q <= '0;
            time_q <= '0;
        end else begin
            if (we.cmd)    cmd_q  <= wdata;
            if (we.timing) time_q <= wdata;
            stat_q <= stat_d;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DW-1:0] keep;
        if (l == 0) begin : g_low
            assign keep = 8'hFC;
        end else begin : g_hi
            assign keep = 8'hFF;
        end
        always_ff @(posedge clk) begin
            if (rst)             ptr_q[l*DW +: DW] <= '0;
            else if (we.lane[l]) ptr_q[l*DW +: DW] <= wdata & keep;
        end
    end

    assign view.cmd    = cmd_q;
    assign view.stat   = stat_q;
    assign view.timing = time_q;
    assign view.ptr    = ptr_q;
endmodule

// File: rtl/ide_mode_irq.sv
module ide_mode_irq
    import ide_dma_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [DW-1:0]  wdata,
    input  logic [NCH-1:0] irq_lvl,
    output logic [DW-1:0]  mode,
    output logic           irq
);
    logic [NCH-1:0] flag_q, blk_q, live;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[c] <= 1'b0;
                blk_q[c]  <= 1'b0;
            end else begin
                flag_q[c] <= irq_lvl[c];
                if (we) blk_q[c] <= wdata[MD_BLOCK_LSB + c];
            end
        end
        assign live[c] = flag_q[c] & ~blk_q[c];
    end

    always_comb begin
        mode = '0;
        mode[MD_FLAG_LSB  +: NCH] = flag_q;
        mode[MD_BLOCK_LSB +: NCH] = blk_q;
    end

    assign irq = |live;
endmodule

// File: rtl/ide_dma_regfile.sv
module ide_dma_regfile
    import ide_dma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NCH-1:0]       chan_irq_in,
    input  logic [NCH-1:0]       eng_active,
    input  logic [NCH-1:0]       eng_err_set,
    input  logic [NCH-1:0]       eng_int_set,
    output logic                 irq_out,
    output logic [NCH*DW-1:0]    chan_cmd,
    output logic [NCH*PTR_W-1:0] desc_addr
);
    chan_we_t   we [NCH];
    chan_view_t view [NCH];
    logic       mode_we;
    logic [DW-1:0] mode_q;
    logic [NCH-1:0][DW-1:0] stat_all;

    ide_addr_dec u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .we      (we),
        .mode_we (mode_we)
    );

    ide_mode_irq u_mode (
        .clk     (clk),
        .rst     (rst),
        .we      (mode_we),
        .wdata   (bus_wdata),
        .irq_lvl (chan_irq_in),
        .mode    (mode_q),
        .irq     (irq_out)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ide_chan_regs u_chan (
            .clk     (clk),
            .rst     (rst),
            .we      (we[c]),
            .wdata   (bus_wdata),
            .active  (eng_active[c]),
            .err_set (eng_err_set[c]),
            .int_set (eng_int_set[c]),
            .view    (view[c])
        );
        assign chan_cmd[c*DW +: DW]        = view[c].cmd;
        assign desc_addr[c*PTR_W +: PTR_W] = view[c].ptr;
        assign stat_all[c]                 = view[c].stat;
    end

    logic [CH_SEL_W-1:0] rch;
    logic [DW-1:0]       rmux;
    assign rch = bus_addr[ADDR_W-1:3];

    always_comb begin
        rmux = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rch == CH_SEL_W'(c)) begin
                if (bus_addr[2]) begin
                    rmux = view[c].ptr[bus_addr[1:0]*DW +: DW];
                end else begin
                    unique case (reg_sel_e'(bus_addr[1:0]))
                        SEL_CMD:  rmux = view[c].cmd;
                        SEL_MODE: rmux = mode_q;
                        SEL_STAT: rmux = view[c].stat;
                        SEL_TIME: rmux = view[c].timing;
                    endcase
                end
            end
        end
    end

    assign bus_rdata = bus_rd ? rmux : '0;
endmodule

// File: rtl/ide_dma_regfile_chk.sv
module ide_dma_regfile_chk
    import ide_dma_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [DW-1:0]          bus_wdata,
    input logic [DW-1:0]          bus_rdata,
    input logic [NCH-1:0]         chan_irq_in,
    input logic [NCH-1:0]         eng_active,
    input logic [NCH-1:0]         eng_int_set,
    input logic                   irq_out,
    input logic [NCH*DW-1:0]      chan_cmd,
    input logic [DW-1:0]          mode_q,
    input logic [NCH-1:0][DW-1:0] stat_all
);
    p_flag_follow_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> mode_q[3:2] == $past(chan_irq_in));

    p_block_written_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_wr) && !$past(rst) && $past(bus_addr[2:0]) == 3'd1)
        |-> mode_q[5:4] == $past(bus_wdata[5:4]));

    p_quiet_no_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(chan_irq_in) == 2'b00) |-> !irq_out);

    p_ch0_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(chan_irq_in[0]) && !mode_q[4]) |-> irq_out);

    p_active_ro_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stat_all[0][0] == $past(eng_active[0])
                     && stat_all[1][0] == $past(eng_active[1]));

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(eng_int_set[0])) |-> stat_all[0][2]);

    p_reset_clear_r11: assert property (@(posedge clk)
        $past(rst) |-> !irq_out && chan_cmd == '0);

    p_idle_read_r12: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);
endmodule

bind ide_dma_regfile ide_dma_regfile_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .chan_irq_in (chan_irq_in),
    .eng_active  (eng_active),
    .eng_int_set (eng_int_set),
    .irq_out     (irq_out),
    .chan_cmd    (chan_cmd),
    .mode_q      (mode_q),
    .stat_all    (stat_all)
);

// File: tb/sim_ide_dma_regfile.sv
module sim_ide_dma_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [1:0]  chan_irq_in = '0, eng_active = '0, eng_err_set = '0, eng_int_set = '0;
    logic        irq_out;
    logic [15:0] chan_cmd;
    logic [63:0] desc_addr;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_dma_regfile u0 (.*);

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(tag, 64'(bus_rdata), 64'(exp));
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11 irq", 64'(irq_out), 0);
        chk("R11 cmd", 64'(chan_cmd), 0);
        chk("R11 ptr", desc_addr, 0);
        for (int a = 0; a < 16; a++) rd(4'(a), 8'h00, "R11 read");

        // R12: no read strobe gives zero
        @(negedge clk);
        bus_addr = 4'd3; bus_rd = 1'b0; #1;
        chk("R12 idle", 64'(bus_rdata), 0);

        // R2 / R1: command sweep per channel
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v += 7) begin
                wr(4'(c*8), 8'(v));
                rd(4'(c*8), 8'(v), "R2 cmd read");
                chk("R2 cmd port", 64'(chan_cmd[c*8 +: 8]), 64'(v));
            end

        // R9: independent timing bytes
        wr(4'd3, 8'hA5);
        wr(4'd11, 8'h3C);
        rd(4'd3, 8'hA5, "R9 t0");
        rd(4'd11, 8'h3C, "R9 t1");

        // R10 / R1: descriptor pointer lanes
        for (int c = 0; c < 2; c++) begin
            logic [31:0] p;
            p = 32'h1357_9BDF + 32'(c) * 32'h0101_0101;
            for (int l = 0; l < 4; l++) wr(4'(c*8 + 4 + l), p[l*8 +: 8]);
            for (int l = 0; l < 4; l++) rd(4'(c*8 + 4 + l), (p & 32'hFFFF_FFFC) >> (l*8), "R10 ptr byte");
            chk("R10 ptr port", 64'(desc_addr[c*32 +: 32]), 64'(p & 32'hFFFF_FFFC));
        end

        // R3: mode write sweep through both windows
        for (int v = 0; v < 256; v++) begin
            wr(v[0] ? 4'd9 : 4'd1, 8'(v));
            rd(4'd1, 8'(v) & 8'h30, "R3 mode");
        end

        // R4 / R5: interrupt combiner sweep
        for (int k = 0; k < 16; k++) begin
            logic [1:0] lv, bk;
            logic e;
            lv = k[1:0]; bk = k[3:2];
            wr(4'd1, {2'b00, bk, 4'h0});
            @(negedge clk);
            chan_irq_in = lv;
            @(negedge clk);
            e = (lv[0] & ~bk[0]) | (lv[1] & ~bk[1]);
            chk("R5 irq", 64'(irq_out), 64'(e));
            rd(4'd9, {2'b00, bk, lv, 2'b00}, "R4 mode flags");
        end
        // R5: block write alone re-evaluates output
        wr(4'd1, 8'h00);
        chk("R5 unblock", 64'(irq_out), 1);
        chan_irq_in = 2'b00;
        @(negedge clk);
        chk("R5 drop", 64'(irq_out), 0);

        // R6 / R7 / R8: status sweep
        for (int c = 0; c < 2; c++)
            for (int v = 0; v < 256; v++) begin
                @(negedge clk);
                eng_active[c] = v[3]; eng_err_set[c] = 1'b1; eng_int_set[c] = 1'b1;
                @(negedge clk);
                eng_err_set = '0; eng_int_set = '0;
                wr(4'(c*8 + 2), 8'(v));
                rd(4'(c*8 + 2), (8'(v) & 8'h60) | (~8'(v) & 8'h06) | 8'(v[3]), "R7 status");
            end
        eng_active = '0;

        // R8: set wins over same-cycle clear
        wr(4'd2, 8'h06);
        @(negedge clk);
        bus_addr = 4'd2; bus_wdata = 8'h04; bus_wr = 1'b1; eng_int_set[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; eng_int_set = '0;
        rd(4'd2, 8'h04, "R8 set wins");
        wr(4'd2, 8'h04);
        rd(4'd2, 8'h00, "R7 plain clear");
        // R6: software cannot set bit 0 or unused bits
        wr(4'd10, 8'hFF);
        rd(4'd10, 8'h60, "R6 ro bits");

        // R11: reset after activity
        chan_irq_in = 2'b01;
        wr(4'd1, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chan_irq_in = 2'b00;
        rst = 1'b0;
        chk("R11 irq after", 64'(irq_out), 0);
        rd(4'd3, 8'h00, "R11 timing");
        rd(4'd10, 8'h00, "R11 status");
        rd(4'd0, 8'h00, "R11 cmd");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule